// File: doc/BRIEF.md
# Two-Stage Clock Synthesizer Configuration Controller

This block sits between a host register bus and a two-stage clock synthesizer. The host issues single-byte writes, each an address with a data byte. The controller keeps staged and active copies of the first-stage divide/multiply pair, the second-stage divide/multiply pair and a mode bit. New settings reach the active copies only when the host writes them in the required order.

Every stored ratio field holds one less than the ratio it stands for. The controller presents the effective ratios, which are the stored codes plus one. For example, a 48 MHz input with first-stage codes 0x7C and 0x5F gives ratios 125 and 96, and so a base of 36.864 MHz.

After each commit, a per-stage lock-pending flag stays raised for a programmable number of cycles. This stands in for the settling time of the analog loop, which is not part of the block.

Top module: `pll_cfg_ctrl`

## Requirements
- R1: While reset is held, and after it is released, every stored code and the mode shadow are zero. The four ratio outputs therefore read 1, and the active mode, the 16/25 enable and both lock-pending flags read 0.
- R2: A write to address 7 stages the first-stage divider code. If the very next write goes to address 8, its data becomes the multiplier code, and both codes become active on that write's clock edge. Idle cycles with no write between the two writes do not break the pair.
- R3: A write to address 8 that does not directly follow an address 7 write leaves the first-stage outputs unchanged and starts no lock window. This includes the case where a write to any other address falls between them.
- R4: A write to address 9 makes data[7:4] the active second-stage divider code and data[3:0] the active second-stage multiplier code, on that write's edge.
- R5: A write to address 10 loads data[0] into a mode shadow. The active mode takes the shadow value only on the edge of the next address 9 write.
- R6: The 16/25 enable output is high exactly when the active mode is 1 and the stored address 9 byte is non-zero.
- R7: After a first-stage commit, the first lock-pending flag is high for exactly LOCK1_CYC cycles, then falls. This holds whatever the mode.
- R8: After an address 9 write, the second lock-pending flag is high for exactly LOCK2_FAST cycles if the newly active mode is 0, and for exactly LOCK2_SLOW cycles if it is 1. With the defaults, both lengths lie between the 100 us equivalent (WIN_MIN) and the 1 ms equivalent (WIN_MAX), and LOCK2_SLOW is greater than LOCK2_FAST.
- R9: A new commit to a stage while its flag is high restarts that stage's full count.
- R10: Writes to addresses other than 7, 8, 9 and 10 change no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe, one write per cycle |
| wr_addr | input | 8 | Register address |
| wr_data | input | 8 | Write data |
| s1_div | output | 9 | Effective first-stage divide ratio (code+1) |
| s1_mul | output | 9 | Effective first-stage multiply ratio (code+1) |
| s2_div | output | 5 | Effective second-stage divide ratio (code+1) |
| s2_mul | output | 5 | Effective second-stage multiply ratio (code+1) |
| mode_act | output | 1 | Active mode bit |
| frac_en | output | 1 | 16/25 extra ratio in effect |
| s1_lock_pend | output | 1 | First-stage lock window running |
| s2_lock_pend | output | 1 | Second-stage lock window running |

## Verification
Every result of a write appears one cycle later. The ratio outputs, the active mode and the rising edge of the relevant lock-pending flag all change on the clock edge that samples the write. The bench drives each write at a falling edge and checks every output at the following falling edge. Its model advances the lock counters once per cycle, so each flag is expected to fall exactly LOCK1_CYC, LOCK2_FAST or LOCK2_SLOW cycles after its commit edge, and every cycle in that window is compared.

// File: rtl/pll_cfg_pkg.sv
package pll_cfg_pkg;
  localparam logic [7:0] ADDR_S1_DIV = 8'd7;
  localparam logic [7:0] ADDR_S1_MUL = 8'd8;
  localparam logic [7:0] ADDR_S2     = 8'd9;
  localparam logic [7:0] ADDR_MODE   = 8'd10;

  typedef struct packed {
    logic [7:0] n1;
    logic [7:0] m1;
    logic [3:0] n2;
    logic [3:0] m2;
    logic       mode;
  } pll_cfg_t;
endpackage

// File: rtl/pll_cfg_seq.sv
module pll_cfg_seq
  import pll_cfg_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [7:0] wr_addr,
  input  logic [7:0] wr_data,
  output pll_cfg_t   act,
  output logic       s1_commit,
  output logic       s2_commit,
  output logic       s2_mode_next
);
  logic       armed_q, armed_d;
  logic [7:0] n1_stage_q, n1_stage_d;
  logic       mode_sh_q, mode_sh_d;
  pll_cfg_t   act_q, act_d;

  logic hit_div, hit_mul, hit_s2, hit_mode;
  assign hit_div  = wr_en && (wr_addr == ADDR_S1_DIV);
  assign hit_mul  = wr_en && (wr_addr == ADDR_S1_MUL);
  assign hit_s2   = wr_en && (wr_addr == ADDR_S2);
  assign hit_mode = wr_en && (wr_addr == ADDR_MODE);

  assign s1_commit    = hit_mul && armed_q;
  assign s2_commit    = hit_s2;
  assign s2_mode_next = mode_sh_q;

  always_comb begin
    armed_d    = armed_q;
    n1_stage_d = n1_stage_q;
    mode_sh_d  = mode_sh_q;
    act_d      = act_q;
    if (wr_en) begin
      armed_d = hit_div;
    end
    if (hit_div) begin
      n1_stage_d = wr_data;
    end
    if (s1_commit) begin
      act_d.n1 = n1_stage_q;
      act_d.m1 = wr_data;
    end
    if (hit_mode) begin
      mode_sh_d = wr_data[0];
    end
    if (hit_s2) begin
      act_d.n2   = wr_data[7:4];
      act_d.m2   = wr_data[3:0];
      act_d.mode = mode_sh_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q    <= 1'b0;
      n1_stage_q <= '0;
      mode_sh_q  <= 1'b0;
      act_q      <= '0;
    end else begin
      armed_q    <= armed_d;
      n1_stage_q <= n1_stage_d;
      mode_sh_q  <= mode_sh_d;
      act_q      <= act_d;
    end
  end

  assign act = act_q;

  a_r3_no_unpaired_commit: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_mul && !armed_q) |=> ($stable(act.n1) && $stable(act.m1)));
  a_r5_mode_held: assert property (@(posedge clk) disable iff (!rst_n)
    !hit_s2 |=> $stable(act.mode));
  a_r4_s2_fields: assert property (@(posedge clk) disable iff (!rst_n)
    hit_s2 |=> (act.n2 == $past(wr_data[7:4]) && act.m2 == $past(wr_data[3:0])));
  a_r2_pair_commit: assert property (@(posedge clk) disable iff (!rst_n)
    s1_commit |=> (act.m1 == $past(wr_data)));
endmodule

// File: rtl/pll_lock_timer.sv
module pll_lock_timer #(
  parameter int unsigned MAX_CYC = 100,
  localparam int unsigned CW = $clog2(MAX_CYC + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [CW-1:0] len,
  output logic          pend
);
  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  assign cnt_en = start || (cnt_q != '0);

  always_comb begin
    cnt_d = cnt_q;
    if (start) begin
      cnt_d = len;
    end else if (cnt_q != '0) begin
      cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign pend = (cnt_q != '0);

  a_r8_within_window: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(MAX_CYC));
  a_r9_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (start && len != '0) |=> (pend && cnt_q == $past(len)));
  a_r7_falls_once: assert property (@(posedge clk) disable iff (!rst_n)
    (!start && !pend) |=> !pend);
endmodule

// File: rtl/pll_cfg_ctrl.sv
module pll_cfg_ctrl
  import pll_cfg_pkg::*;
#(
  parameter int unsigned WIN_MIN    = 10,
  parameter int unsigned WIN_MAX    = 100,
  parameter int unsigned LOCK1_CYC  = 40,
  parameter int unsigned LOCK2_FAST = 20,
  parameter int unsigned LOCK2_SLOW = 70
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [7:0] wr_addr,
  input  logic [7:0] wr_data,
  output logic [8:0] s1_div,
  output logic [8:0] s1_mul,
  output logic [4:0] s2_div,
  output logic [4:0] s2_mul,
  output logic       mode_act,
  output logic       frac_en,
  output logic       s1_lock_pend,
  output logic       s2_lock_pend
);
  localparam int unsigned CW = $clog2(WIN_MAX + 1);

  pll_cfg_t act;
  logic     s1_commit, s2_commit, s2_mode_next;
  logic [CW-1:0] len1, len2;

  pll_cfg_seq u_seq (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .act(act), .s1_commit(s1_commit),
    .s2_commit(s2_commit), .s2_mode_next(s2_mode_next)
  );

  assign len1 = CW'(LOCK1_CYC);
  assign len2 = s2_mode_next ? CW'(LOCK2_SLOW) : CW'(LOCK2_FAST);

  pll_lock_timer #(.MAX_CYC(WIN_MAX)) u_lock1 (
    .clk(clk), .rst_n(rst_n), .start(s1_commit), .len(len1), .pend(s1_lock_pend)
  );
  pll_lock_timer #(.MAX_CYC(WIN_MAX)) u_lock2 (
    .clk(clk), .rst_n(rst_n), .start(s2_commit), .len(len2), .pend(s2_lock_pend)
  );

  assign s1_div   = {1'b0, act.n1} + 9'd1;
  assign s1_mul   = {1'b0, act.m1} + 9'd1;
  assign s2_div   = {1'b0, act.n2} + 5'd1;
  assign s2_mul   = {1'b0, act.m2} + 5'd1;
  assign mode_act = act.mode;
  assign frac_en  = act.mode && ({act.n2, act.m2} != 8'd0);

  a_r8_slow_longer: assert property (@(posedge clk) disable iff (!rst_n)
    (s2_commit && s2_mode_next) |=> s2_lock_pend);
  a_r2_pend_on_commit: assert property (@(posedge clk) disable iff (!rst_n)
    s1_commit |=> s1_lock_pend);
  a_r1_ratio_floor: assert property (@(posedge clk) disable iff (!rst_n)
    (s1_div != 9'd0) && (s2_div != 5'd0));
endmodule

// File: tb/pll_cfg_ctrl_test.sv
`timescale 1ns/1ps
module pll_cfg_ctrl_test;
  localparam int unsigned L1 = 40, LF = 20, LS = 70;

  logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0;
  logic [7:0] wr_addr = '0, wr_data = '0;
  logic [8:0] s1_div, s1_mul;
  logic [4:0] s2_div, s2_mul;
  logic mode_act, frac_en, s1_lock_pend, s2_lock_pend;

  int n_chk = 0, n_fail = 0;
  int unsigned seed = 32'd1234;
  bit done = 1'b0;

  int m_n1, m_m1, m_n2, m_m2, m_stage, m_cnt1, m_cnt2;
  bit m_mode, m_sh, m_armed;

  always #2.5 clk = ~clk;

  pll_cfg_ctrl uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .s1_div(s1_div), .s1_mul(s1_mul), .s2_div(s2_div), .s2_mul(s2_mul),
    .mode_act(mode_act), .frac_en(frac_en),
    .s1_lock_pend(s1_lock_pend), .s2_lock_pend(s2_lock_pend)
  );

  function automatic bit exp_frac();
    return m_mode && ((m_n2 != 0) || (m_m2 != 0));
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic check_all(input string tag);
    chk({tag, " R2 s1_div"}, s1_div, m_n1 + 1);
    chk({tag, " R2 s1_mul"}, s1_mul, m_m1 + 1);
    chk({tag, " R4 s2_div"}, s2_div, m_n2 + 1);
    chk({tag, " R4 s2_mul"}, s2_mul, m_m2 + 1);
    chk({tag, " R5 mode"}, mode_act, m_mode);
    chk({tag, " R6 frac_en"}, frac_en, exp_frac());
    chk({tag, " R7 s1 pend"}, s1_lock_pend, m_cnt1 != 0);
    chk({tag, " R8 s2 pend"}, s2_lock_pend, m_cnt2 != 0);
  endtask

  // one cycle: drive at negedge, model the edge, check at next negedge
  task automatic cyc(input bit en, input logic [7:0] a, input logic [7:0] d,
                     input string tag);
    wr_en = en; wr_addr = a; wr_data = d;
    @(negedge clk);
    if (m_cnt1 != 0) m_cnt1--;
    if (m_cnt2 != 0) m_cnt2--;
    if (en) begin
      if (a == 8'd8 && m_armed) begin
        m_n1 = m_stage; m_m1 = d; m_cnt1 = L1;
      end
      if (a == 8'd7) m_stage = d;
      if (a == 8'd9) begin
        m_n2 = d[7:4]; m_m2 = d[3:0]; m_mode = m_sh;
        m_cnt2 = m_sh ? LS : LF;
      end
      if (a == 8'd10) m_sh = d[0];
      m_armed = (a == 8'd7);
    end
    check_all(tag);
  endtask

  task automatic idle(input int n, input string tag);
    for (int i = 0; i < n; i++) cyc(1'b0, 8'd0, 8'd0, tag);
  endtask

  initial begin
    m_n1 = 0; m_m1 = 0; m_n2 = 0; m_m2 = 0; m_stage = 0;
    m_cnt1 = 0; m_cnt2 = 0; m_mode = 0; m_sh = 0; m_armed = 0;
    repeat (3) @(negedge clk);
    check_all("R1 in reset");
    rst_n = 1'b1;
    @(negedge clk);
    check_all("R1 after reset");

    // R2: 48 MHz example, codes 7C/5F -> 125/96
    cyc(1'b1, 8'd7, 8'h7C, "R2 stage");
    idle(2, "R2 gap");
    cyc(1'b1, 8'd8, 8'h5F, "R2 commit");
    chk("R2 div 125", s1_div, 125);
    chk("R2 mul 96", s1_mul, 96);
    idle(L1 + 2, "R7 window");
    // R3: lone 8, and 7 then 6 then 8
    cyc(1'b1, 8'd8, 8'h11, "R3 lone");
    cyc(1'b1, 8'd7, 8'h22, "R3 stage");
    cyc(1'b1, 8'd6, 8'h33, "R10 breaker");
    cyc(1'b1, 8'd8, 8'h44, "R3 broken");
    chk("R3 unchanged", s1_mul, 96);
    // R5/R6: mode shadowed; zero reg9 gives no frac
    cyc(1'b1, 8'd10, 8'h01, "R5 shadow");
    chk("R5 not yet", mode_act, 0);
    cyc(1'b1, 8'd9, 8'h00, "R6 zero reg9");
    chk("R6 frac off", frac_en, 0);
    idle(LS + 2, "R8 slow window");
    cyc(1'b1, 8'd9, 8'h29, "R6 nonzero");
    chk("R6 frac on", frac_en, 1);
    idle(30, "R9 pre");
    cyc(1'b1, 8'd9, 8'h29, "R9 restart");
    idle(LS + 2, "R9 post");
    cyc(1'b1, 8'd10, 8'h00, "R5 clear");
    cyc(1'b1, 8'd9, 8'h74, "R8 fast");
    idle(LF + 2, "R8 fast window");
    // R10: junk addresses
    cyc(1'b1, 8'hFF, 8'hAA, "R10 ignored");
    cyc(1'b1, 8'd0, 8'h55, "R10 ignored");

    // random mix
    for (int k = 0; k < 4000; k++) begin
      int unsigned r;
      logic [7:0] a;
      r = $urandom(seed) % 8;
      seed = seed + 32'd7919;
      case (r)
        0, 1: a = 8'd7;
        2, 3: a = 8'd8;
        4: a = 8'd9;
        5: a = 8'd10;
        default: a = 8'($urandom(seed + 1));
      endcase
      cyc(($urandom(seed + 2) % 3) != 0, a, 8'($urandom(seed + 3)), "rand R2 R3 R9 R10");
    end
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: got hang expected finish");
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule